// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block produces the next instruction fetch address for a simple fetch stage and lets a program repeat a block of code a set number of times without spending a branch instruction or a lost cycle on each pass. Software loads, in one setup cycle, the address of the first instruction of the body, the address of its last instruction and the number of passes. From then on the fetch address generator watches for the last body address. When it sees that address it sends fetch straight back to the first body address in the very next cycle. It keeps doing this until the passes are used up, then lets fetch fall through to the instruction after the body.

A stall input freezes the fetch address and the loop state. A branch request from later pipeline stages overrides both the loop jump and the normal step for that cycle and leaves the loop state alone. Only one loop level exists, and a new setup replaces whatever loop is in progress. The remaining pass count and an active flag are visible at the ports.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset the fetch address is 0, `loop_active` is 0 and `loop_remaining` is 0.
- R2: When `cfg_load` is 1 at a clock edge, the start address, end address and pass count are captured in that edge. `loop_remaining` becomes `cfg_count`, and `loop_active` becomes 1 exactly when `cfg_count` is nonzero. This happens whether or not fetch is stalled. In a load cycle the fetch address takes a branch or a sequential step as usual, but it never takes a loop jump.
- R3: While active and unstalled with no branch, if the fetch address equals the end address and `loop_remaining` is greater than 1, the next fetch address is the start address and `loop_remaining` drops by 1. No idle cycle lies between the end address and the start address.
- R4: While active and unstalled with no branch, if the fetch address equals the end address and `loop_remaining` is 1, the next fetch address is the end address plus 1, `loop_remaining` becomes 0 and `loop_active` becomes 0. A loaded count of N therefore fetches the body exactly N times.
- R5: A loaded count of 0 leaves the loop inactive. Fetch runs through the body once in sequence and continues past the end address.
- R6: While `fetch_en` is 0, the fetch address, `loop_remaining` and `loop_active` hold, apart from a setup load. Any number of stalled cycles at the end address cost the count at most one decrement.
- R7: While `fetch_en` is 1 and `br_take` is 1, the next fetch address is `br_target`, even at the end address of an active loop. `loop_remaining` and `loop_active` are unchanged unless a load happens in that cycle.
- R8: In any other unstalled cycle, including reaching the end address while inactive, the fetch address advances by 1.
- R9: A setup load while a loop is active discards the old loop. Only the new start, end and count govern later jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Setup strobe: capture start, end and count |
| cfg_start | input | AW | First body address |
| cfg_end | input | AW | Last body address |
| cfg_count | input | CW | Number of body passes |
| fetch_en | input | 1 | 1 = fetch advances, 0 = stall |
| br_take | input | 1 | External branch request |
| br_target | input | AW | Branch destination |
| fetch_pc | output | AW | Current fetch address |
| loop_active | output | 1 | Loop is armed |
| loop_remaining | output | CW | Passes left, counting the one in progress |

## Verification
The main function is tried with pass counts of 3, 1 and 0 on bodies of different lengths. These cases separate a correct jump-back from an off-by-one in the pass count and from a zero count being taken as a loop. A stall held on the end address shows whether the count drops once or once per cycle. Branches taken on the end address and in the middle of a loop show whether the branch wins while the loop state is preserved. A reload during an active loop shows whether the old end address is still honoured.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    // Source of the next fetch address
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_SEQ    = 2'd1,
        SRC_LOOP   = 2'd2,
        SRC_BRANCH = 2'd3
    } pc_src_e;

endpackage

// File: rtl/hwloop_decide.sv
module hwloop_decide
    import hwloop_pkg::*;
(
    input  logic    fetch_en,
    input  logic    br_take,
    input  logic    cfg_load,
    input  logic    active,
    input  logic    at_end,
    input  logic    count_last,
    output pc_src_e pc_src,
    output logic    dec_count
);

    always_comb begin
        pc_src    = SRC_SEQ;
        dec_count = 1'b0;
        if (!fetch_en) begin
            pc_src = SRC_HOLD;
        end else if (br_take) begin
            pc_src = SRC_BRANCH;
        end else if (!cfg_load && active && at_end) begin
            dec_count = 1'b1;
            pc_src    = count_last ? SRC_SEQ : SRC_LOOP;
        end
    end

endmodule

// File: rtl/hwloop_state.sv
module hwloop_state #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_start,
    input  logic [AW-1:0] load_end,
    input  logic [CW-1:0] load_count,
    input  logic          dec,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_addr,
    output logic [CW-1:0] count,
    output logic          active
);

    typedef struct packed {
        logic [AW-1:0] start_a;
        logic [AW-1:0] end_a;
        logic [CW-1:0] cnt;
        logic          act;
    } loop_state_t;

    loop_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.start_a = load_start;
            st_d.end_a   = load_end;
            st_d.cnt     = load_count;
            st_d.act     = (load_count != '0);
        end else if (dec) begin
            st_d.cnt = st_q.cnt - CW'(1);
            st_d.act = (st_q.cnt != CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_addr = st_q.start_a;
    assign end_addr   = st_q.end_a;
    assign count      = st_q.cnt;
    assign active     = st_q.act;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_count)) && (active == ($past(load_count) != '0)));

    p_inactive_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (count == '0));

endmodule

// File: rtl/hwloop_pcgen.sv
module hwloop_pcgen
    import hwloop_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_src_e       pc_src,
    input  logic [AW-1:0] loop_start,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] pc
);

    logic [AW-1:0] pc_d, pc_q;

    always_comb begin
        unique case (pc_src)
            SRC_HOLD:   pc_d = pc_q;
            SRC_SEQ:    pc_d = pc_q + AW'(1);
            SRC_LOOP:   pc_d = loop_start;
            SRC_BRANCH: pc_d = br_target;
            default:    pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW-1:0] cfg_end,
    input  logic [CW-1:0] cfg_count,
    input  logic          fetch_en,
    input  logic          br_take,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] fetch_pc,
    output logic          loop_active,
    output logic [CW-1:0] loop_remaining
);

    logic [AW-1:0] start_addr, end_addr;
    logic          at_end, count_last, dec_count;
    pc_src_e       pc_src;

    assign at_end     = (fetch_pc == end_addr);
    assign count_last = (loop_remaining == CW'(1));

    hwloop_state #(.AW(AW), .CW(CW)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .load_start (cfg_start),
        .load_end   (cfg_end),
        .load_count (cfg_count),
        .dec        (dec_count),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .count      (loop_remaining),
        .active     (loop_active)
    );

    hwloop_decide u_decide (
        .fetch_en   (fetch_en),
        .br_take    (br_take),
        .cfg_load   (cfg_load),
        .active     (loop_active),
        .at_end     (at_end),
        .count_last (count_last),
        .pc_src     (pc_src),
        .dec_count  (dec_count)
    );

    hwloop_pcgen #(.AW(AW)) u_pcgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_src     (pc_src),
        .loop_start (start_addr),
        .br_target  (br_target),
        .pc         (fetch_pc)
    );

    p_jump_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en && !br_take && !cfg_load && loop_active && (fetch_pc == end_addr)
        && (loop_remaining > CW'(1))
        |=> (fetch_pc == $past(start_addr)) && (loop_remaining == $past(loop_remaining) - CW'(1)));

    p_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en && !br_take && !cfg_load && loop_active && (fetch_pc == end_addr)
        && (loop_remaining == CW'(1))
        |=> (fetch_pc == $past(fetch_pc) + AW'(1)) && !loop_active);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en && !cfg_load
        |=> $stable(fetch_pc) && $stable(loop_remaining) && $stable(loop_active));

    p_branch_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en && br_take && !cfg_load
        |=> (fetch_pc == $past(br_target)) && $stable(loop_remaining) && $stable(loop_active));

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en && !br_take && !(loop_active && !cfg_load && (fetch_pc == end_addr))
        |=> (fetch_pc == $past(fetch_pc) + AW'(1)));

endmodule

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb;

    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_start = '0;
    logic [AW-1:0] cfg_end = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          fetch_en = 1'b1;
    logic          br_take = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [AW-1:0] fetch_pc;
    logic          loop_active;
    logic [CW-1:0] loop_remaining;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    hwloop_ctrl #(.AW(AW), .CW(CW)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_load       (cfg_load),
        .cfg_start      (cfg_start),
        .cfg_end        (cfg_end),
        .cfg_count      (cfg_count),
        .fetch_en       (fetch_en),
        .br_take        (br_take),
        .br_target      (br_target),
        .fetch_pc       (fetch_pc),
        .loop_active    (loop_active),
        .loop_remaining (loop_remaining)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int exp_pc, input logic exp_act, input int exp_rem);
        n_checks++;
        if (fetch_pc !== AW'(exp_pc) || loop_active !== exp_act || loop_remaining !== CW'(exp_rem)) begin
            n_errors++;
            $display("FAIL %s: pc=%0d act=%0b rem=%0d expected pc=%0d act=%0b rem=%0d",
                     tag, fetch_pc, loop_active, loop_remaining, exp_pc, exp_act, exp_rem);
        end
    endtask

    task automatic jump_to(input int target, input logic act, input int rem);
        br_take = 1'b1; br_target = AW'(target);
        step();
        br_take = 1'b0;
        chk("R7 branch positioning", target, act, rem);
    endtask

    // Load at address s-2, so the load cycle steps to s-1, then run the body n times
    task automatic run_loop(input string tag, input int s, input int e, input int n);
        jump_to(s - 2, loop_active, loop_remaining);
        cfg_load = 1'b1; cfg_start = AW'(s); cfg_end = AW'(e); cfg_count = CW'(n);
        step();
        cfg_load = 1'b0;
        chk({tag, " R2 load"}, s - 1, n != 0, n);
        for (int it = 0; it < ((n == 0) ? 1 : n); it++) begin
            for (int a = s; a <= e; a++) begin
                step();
                chk({tag, " R3 body"}, a, n != 0, (n == 0) ? 0 : n - it);
            end
        end
        step();
        chk({tag, " R4 fall through"}, e + 1, 1'b0, 0);
        step();
        chk({tag, " R8 after loop"}, e + 2, 1'b0, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset", 0, 1'b0, 0);
        step();
        chk("R8 step from reset", 1, 1'b0, 0);
    endtask

    task automatic t_stall();
        jump_to(38, loop_active, loop_remaining);
        cfg_load = 1'b1; cfg_start = 40; cfg_end = 41; cfg_count = 2;
        step();
        cfg_load = 1'b0;
        step(); chk("R6 pre", 40, 1'b1, 2);
        step(); chk("R6 at end", 41, 1'b1, 2);
        fetch_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step(); chk("R6 stalled at end", 41, 1'b1, 2);
        end
        fetch_en = 1'b1;
        step(); chk("R6 single decrement", 40, 1'b1, 1);
        step(); chk("R6 second pass", 41, 1'b1, 1);
        step(); chk("R4 exit after stall", 42, 1'b0, 0);
    endtask

    task automatic t_branch();
        jump_to(48, loop_active, loop_remaining);
        cfg_load = 1'b1; cfg_start = 50; cfg_end = 52; cfg_count = 3;
        step();
        cfg_load = 1'b0;
        jump_to(52, 1'b1, 3);
        br_take = 1'b1; br_target = 60;
        step();
        br_take = 1'b0;
        chk("R7 branch beats loop jump", 60, 1'b1, 3);
        step(); chk("R8 step after branch", 61, 1'b1, 3);
        jump_to(52, 1'b1, 3);
        step(); chk("R3 jump back after branch", 50, 1'b1, 2);
        // R9: reload in mid-loop, then old end 52 must be ignored
        cfg_load = 1'b1; cfg_start = 70; cfg_end = 71; cfg_count = 2;
        step();
        cfg_load = 1'b0;
        chk("R9 reload", 51, 1'b1, 2);
        step(); chk("R9 old end ignored", 52, 1'b1, 2);
        step(); chk("R9 passes old end", 53, 1'b1, 2);
        jump_to(71, 1'b1, 2);
        step(); chk("R9 new loop jumps", 70, 1'b1, 1);
        step(); chk("R9 new loop end", 71, 1'b1, 1);
        step(); chk("R9 new loop exit", 72, 1'b0, 0);
    endtask

    task automatic t_load_at_end();
        // R2: a load in the cycle at the old end address takes no loop jump
        jump_to(78, loop_active, loop_remaining);
        cfg_load = 1'b1; cfg_start = 80; cfg_end = 81; cfg_count = 2;
        step();
        cfg_load = 1'b0;
        step(); step();
        chk("R2 at old end", 81, 1'b1, 2);
        cfg_load = 1'b1; cfg_start = 90; cfg_end = 95; cfg_count = 1;
        step();
        cfg_load = 1'b0;
        chk("R2 load cycle steps sequentially", 82, 1'b1, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_loop("N3", 18, 20, 3);
        run_loop("N1", 30, 33, 1);
        run_loop("R5 N0", 100, 102, 0);
        run_loop("single word", 120, 120, 4);
        t_stall();
        t_branch();
        t_load_at_end();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule